// File: doc/BRIEF.md
# LCD Segment Data Serializer

This block turns pattern bytes for the two halves of a dot-matrix LCD panel (upper and lower) into the bit streams that segment drivers shift in. A dot counter divides the dot clock into characters of Hp dots each. A character counter then splits every display line into a blanking stretch of eight characters followed by HN active characters. During the active characters, each half emits the Hp most significant bits of its byte, one bit per dot. These bits are packed into groups of one, two or four, depending on the output mode. Each finished group is presented on the data lanes together with a one-dot shift pulse.

The blanking stretch carries the line-latch pulse, the driver chip-enable pulse and a busy flag. A fetch unit or a CPU can use the busy flag to reach display memory without disturbing the picture. A frame flag changes level after a programmable number of lines, so the panel receives AC-inverted drive. The fetch logic watches the character strobe and presents the next character's bytes on the cycle in which the strobe is high. When the display is switched off, the data lanes stay low while all timing continues.

Top module: `lcd_seg_serializer`

## Requirements
- R1: `chr_o` is high on the last dot of each character, so one character lasts Hp = `hp_m1_i`+1 dots. A `hp_m1_i` value below 3 behaves as 3 (Hp = 4).
- R2: A line has HN+8 characters, where HN = `hn_m1_i`+1. Characters 0..7 of the line are blanking and characters 8..HN+7 are active. The bytes are sampled at the clock edge that ends a `chr_o` cycle and are shown during the next character. Each half forms a stream of the Hp most significant bits of each byte, bit 7 first, and the stream runs on without a break from one character to the next within a line.
- R3: `mode_i` sets the group width: 0 gives 1 bit, 1 gives 2 bits, and 2 or 3 give 4 bits. A line therefore carries floor(HN·Hp/width) shift pulses, which places the shift rate at the dot rate, half the dot rate or a quarter of the dot rate.
- R4: In mode 0, `ud_o[0]` carries the upper stream bit and `ud_o[1]` carries the lower stream bit. `ud_o[3:2]` and `ld_o` are 0.
- R5: In mode 1, `ud_o[0]` and `ud_o[1]` carry the first and second upper bits of a group, and `ud_o[2]` and `ud_o[3]` carry the first and second lower bits. `ld_o` is 0.
- R6: In modes 2 and 3, `ud_o[3]..ud_o[0]` carry the four upper bits of a group in stream order, and `ld_o[3]..ld_o[0]` carry the four lower bits in the same way.
- R7: `clp_o` is high for exactly the one cycle that follows the active dot completing a group, and the data lanes take the new group in that same cycle. A group left incomplete at the end of a line is dropped. No other cycle carries a pulse.
- R8: `busy_o` is high during blanking characters 0..6, `lip_o` during characters 1..2 and `ce_o` during character 3.
- R9: `frm_o` changes level once every `duty_m1_i`+1 lines, right after the last dot of the last line of the frame.
- R10: While `disp_on_i` is low, every group is shown as zeros and the shift pulses keep their timing.
- R11: While `rst_n` is low, `ud_o`, `ld_o`, `clp_o`, `frm_o` and `chr_o` are 0, and the line restarts at blanking character 0, dot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upper_i | input | 8 | Pattern byte, upper half |
| lower_i | input | 8 | Pattern byte, lower half |
| hp_m1_i | input | 3 | Character pitch minus one |
| hn_m1_i | input | 7 | Active characters per line minus one |
| duty_m1_i | input | 8 | Lines per frame minus one |
| mode_i | input | 2 | Output mode: 0 serial, 1 two-bit, 2/3 four-bit |
| disp_on_i | input | 1 | Display enable |
| ud_o | output | 4 | Upper data lanes (lower half too in modes 0 and 1) |
| ld_o | output | 4 | Lower data lanes in four-bit mode |
| clp_o | output | 1 | Shift pulse |
| chr_o | output | 1 | Character strobe, last dot |
| lip_o | output | 1 | Line latch pulse |
| ce_o | output | 1 | Driver chip-enable pulse |
| busy_o | output | 1 | Blanking busy flag |
| frm_o | output | 1 | Frame alternation flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 7-bit character count and an 8-bit line count. It then runs it with small values of HN (2 to 4) and of the line count (2 to 4), so that several complete lines and frame changes fit into a few hundred cycles per scenario. Pitches of 5 and 6 with the two-bit and four-bit modes put groups across character boundaries and leave incomplete groups at the end of a line. A pitch setting of 1 exercises the clamp to Hp = 4.

// File: rtl/lcdser_pkg.sv
// Shared constants and helpers for the LCD segment serializer.
// Assumes an eight-character blanking stretch per line.
package lcdser_pkg;
    typedef enum logic [1:0] {
        OUT_SER1  = 2'd0,
        OUT_PAR2  = 2'd1,
        OUT_PAR4  = 2'd2,
        OUT_PAR4B = 2'd3
    } out_mode_e;

    localparam int BLANK_CH  = 8;
    localparam int BUSY_CH   = 7;
    localparam int LIP_FIRST = 1;
    localparam int LIP_CH    = 2;
    localparam int CE_FIRST  = 3;

    // Index of the last bit in a group for the given mode.
    function automatic logic [1:0] group_last(input out_mode_e m);
        case (m)
            OUT_SER1: return 2'd0;
            OUT_PAR2: return 2'd1;
            default:  return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/lcdser_timing.sv
// Dot, character and line counters with blanking pulse decode.
// Assumes hp_m1 below 3 should act as 3; the line starts with blanking.
module lcdser_timing
    import lcdser_pkg::*;
#(
    parameter int DOT_W  = 3,
    parameter int HN_W   = 7,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  hp_m1,
    input  logic [HN_W-1:0]   hn_m1,
    input  logic [DUTY_W-1:0] duty_m1,
    output logic [DOT_W-1:0]  dot_o,
    output logic              char_end_o,
    output logic              active_o,
    output logic              busy_o,
    output logic              lip_o,
    output logic              ce_o,
    output logic              frm_o
);
    localparam int CC_W = $clog2((1 << HN_W) + BLANK_CH);
    localparam logic [DOT_W-1:0] HP_MIN  = DOT_W'(3);
    localparam logic [CC_W-1:0]  C_BLANK = CC_W'(BLANK_CH);
    localparam logic [CC_W-1:0]  C_BUSY  = CC_W'(BUSY_CH);
    localparam logic [CC_W-1:0]  C_LIP0  = CC_W'(LIP_FIRST);
    localparam logic [CC_W-1:0]  C_LIP1  = CC_W'(LIP_FIRST + LIP_CH);
    localparam logic [CC_W-1:0]  C_CE    = CC_W'(CE_FIRST);

    logic [DOT_W-1:0]  dcnt;
    logic [CC_W-1:0]   ccnt;
    logic [DUTY_W-1:0] lcnt;
    logic              frm_q;
    logic [DOT_W-1:0]  hp_eff;
    logic [CC_W-1:0]   last_ch;
    logic              char_end, line_end;

    // Effective pitch and end-of-character / end-of-line decode.
    always_comb begin
        hp_eff   = (hp_m1 < HP_MIN) ? HP_MIN : hp_m1;
        last_ch  = C_BLANK + CC_W'(hn_m1);
        char_end = (dcnt >= hp_eff);
        line_end = char_end && (ccnt >= last_ch);
    end

    // Dot and character counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= '0;
            ccnt <= '0;
        end else if (char_end) begin
            dcnt <= '0;
            ccnt <= line_end ? '0 : ccnt + 1'b1;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    // Line counter and frame alternation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcnt  <= '0;
            frm_q <= 1'b0;
        end else if (line_end) begin
            if (lcnt >= duty_m1) begin
                lcnt  <= '0;
                frm_q <= ~frm_q;
            end else begin
                lcnt <= lcnt + 1'b1;
            end
        end
    end

    assign dot_o      = dcnt;
    assign char_end_o = char_end;
    assign active_o   = (ccnt >= C_BLANK);
    assign busy_o     = (ccnt < C_BUSY);
    assign lip_o      = (ccnt >= C_LIP0) && (ccnt < C_LIP1);
    assign ce_o       = (ccnt == C_CE);
    assign frm_o      = frm_q;

    AST_FRM_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q != $past(frm_q)) |-> $past(line_end)); // R9
    AST_CE_AFTER_LIP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lip_o) |-> ce_o); // R8
endmodule

// File: rtl/lcdser_half.sv
// One panel half: holds the fetched byte and offers the group being built.
// Assumes the dot index never exceeds the byte's top bit position.
module lcdser_half #(
    parameter int BYTE_W = 8,
    parameter int DOT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic [DOT_W-1:0]  dot_i,
    output logic [3:0]        grp_o
);
    localparam logic [DOT_W-1:0] TOP = DOT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] hold;
    logic [2:0]        sr;
    logic              pix;

    // Pixel of the current dot, most significant bit first.
    assign pix   = hold[TOP - dot_i];
    assign grp_o = {sr, pix};

    // Capture the next character's byte and collect emitted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            sr   <= '0;
        end else begin
            if (cap_i)   hold <= byte_i;
            if (shift_i) sr   <= grp_o[2:0];
        end
    end

    AST_HOLD_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold != $past(hold)) |-> $past(cap_i)); // R2
endmodule

// File: rtl/lcdser_lanes.sv
// Group counter and mode-dependent lane mapping with the shift pulse.
// Assumes both halves deliver their groups in the same cycle.
module lcdser_lanes
    import lcdser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       disp_on_i,
    input  logic       shift_i,
    input  logic [3:0] grp_u_i,
    input  logic [3:0] grp_l_i,
    output logic [3:0] ud_o,
    output logic [3:0] ld_o,
    output logic       clp_o
);
    out_mode_e  m;
    logic [1:0] gcnt;
    logic [3:0] nxt_ud, nxt_ld;

    assign m = out_mode_e'(mode_i);

    // Lane arrangement for the selected mode, blanked when display is off.
    always_comb begin
        case (m)
            OUT_SER1: begin
                nxt_ud = {2'b00, grp_l_i[0], grp_u_i[0]};
                nxt_ld = 4'h0;
            end
            OUT_PAR2: begin
                nxt_ud = {grp_l_i[0], grp_l_i[1], grp_u_i[0], grp_u_i[1]};
                nxt_ld = 4'h0;
            end
            default: begin
                nxt_ud = grp_u_i;
                nxt_ld = grp_l_i;
            end
        endcase
        if (!disp_on_i) begin
            nxt_ud = 4'h0;
            nxt_ld = 4'h0;
        end
    end

    // Count bits per group; present the group and pulse on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt  <= '0;
            clp_o <= 1'b0;
            ud_o  <= '0;
            ld_o  <= '0;
        end else begin
            clp_o <= 1'b0;
            if (!shift_i) begin
                gcnt <= '0;
            end else if (gcnt >= group_last(m)) begin
                gcnt  <= '0;
                clp_o <= 1'b1;
                ud_o  <= nxt_ud;
                ld_o  <= nxt_ld;
            end else begin
                gcnt <= gcnt + 1'b1;
            end
        end
    end

    AST_PULSE_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        clp_o |-> $past(shift_i)); // R7
    AST_SERIAL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (clp_o && $past(mode_i) == 2'd0) |-> (ud_o[3:2] == 2'b00 && ld_o == 4'h0)); // R4
    AST_DARK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (clp_o && !$past(disp_on_i)) |-> (ud_o == 4'h0 && ld_o == 4'h0)); // R10
endmodule

// File: rtl/lcd_seg_serializer.sv
// Top: timing generator, two half packers and the lane mapper.
// Assumes byte inputs are presented during the chr_o cycle for the next character.
module lcd_seg_serializer #(
    parameter int BYTE_W = 8,
    parameter int DOT_W  = $clog2(BYTE_W),
    parameter int HN_W   = 7,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] upper_i,
    input  logic [BYTE_W-1:0] lower_i,
    input  logic [DOT_W-1:0]  hp_m1_i,
    input  logic [HN_W-1:0]   hn_m1_i,
    input  logic [DUTY_W-1:0] duty_m1_i,
    input  logic [1:0]        mode_i,
    input  logic              disp_on_i,
    output logic [3:0]        ud_o,
    output logic [3:0]        ld_o,
    output logic              clp_o,
    output logic              chr_o,
    output logic              lip_o,
    output logic              ce_o,
    output logic              busy_o,
    output logic              frm_o
);
    localparam int HALVES = 2;

    logic [DOT_W-1:0]  dot;
    logic              char_end, active;
    logic [BYTE_W-1:0] bytes [HALVES];
    logic [3:0]        grps  [HALVES];

    assign bytes[0] = upper_i;
    assign bytes[1] = lower_i;
    assign chr_o    = char_end;

    lcdser_timing #(.DOT_W(DOT_W), .HN_W(HN_W), .DUTY_W(DUTY_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .hp_m1(hp_m1_i), .hn_m1(hn_m1_i),
        .duty_m1(duty_m1_i), .dot_o(dot), .char_end_o(char_end),
        .active_o(active), .busy_o(busy_o), .lip_o(lip_o), .ce_o(ce_o),
        .frm_o(frm_o)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        lcdser_half #(.BYTE_W(BYTE_W), .DOT_W(DOT_W)) u_half (
            .clk(clk), .rst_n(rst_n), .byte_i(bytes[h]), .cap_i(char_end),
            .shift_i(active), .dot_i(dot), .grp_o(grps[h])
        );
    end

    lcdser_lanes u_lanes (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .disp_on_i(disp_on_i),
        .shift_i(active), .grp_u_i(grps[0]), .grp_l_i(grps[1]),
        .ud_o(ud_o), .ld_o(ld_o), .clp_o(clp_o)
    );
endmodule

// File: tb/sim_lcd_seg_serializer.sv
`timescale 1ns/1ps
module sim_lcd_seg_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] upper_i = '0, lower_i = '0;
    logic [2:0] hp_m1_i = 3'd7;
    logic [6:0] hn_m1_i = 7'd2;
    logic [7:0] duty_m1_i = 8'd1;
    logic [1:0] mode_i = 2'd0;
    logic       disp_on_i = 1'b1;
    logic [3:0] ud_o, ld_o;
    logic       clp_o, chr_o, lip_o, ce_o, busy_o, frm_o;
    int         n_checks = 0, n_errors = 0;

    always #2 clk = ~clk;

    lcd_seg_serializer u0 (
        .clk(clk), .rst_n(rst_n), .upper_i(upper_i), .lower_i(lower_i),
        .hp_m1_i(hp_m1_i), .hn_m1_i(hn_m1_i), .duty_m1_i(duty_m1_i),
        .mode_i(mode_i), .disp_on_i(disp_on_i), .ud_o(ud_o), .ld_o(ld_o),
        .clp_o(clp_o), .chr_o(chr_o), .lip_o(lip_o), .ce_o(ce_o),
        .busy_o(busy_o), .frm_o(frm_o)
    );

    task automatic chk(input bit ok, input string req, input string tag,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int ln, int j, int half);
        return 8'((ln * 53 + j * 29 + half * 101 + 7) ^ (j * 3));
    endfunction

    function automatic logic sbit(int ln, int half, int s, int hp);
        logic [7:0] b;
        b = pat(ln, s / hp, half);
        return b[7 - (s % hp)];
    endfunction

    // Expected {ld, ud} for a group starting at stream bit s0.
    function automatic logic [7:0] exp_lanes(int m, int ln, int s0, int hp, bit on);
        logic [3:0] ub, lb, ud, ld;
        for (int i = 0; i < 4; i++) begin
            ub[i] = sbit(ln, 0, s0 + i, hp);
            lb[i] = sbit(ln, 1, s0 + i, hp);
        end
        case (m)
            0: begin ud = {2'b00, lb[0], ub[0]}; ld = 4'h0; end
            1: begin ud = {lb[1], lb[0], ub[1], ub[0]}; ld = 4'h0; end
            default: begin
                ud = {ub[0], ub[1], ub[2], ub[3]};
                ld = {lb[0], lb[1], lb[2], lb[3]};
            end
        endcase
        if (!on) begin ud = 4'h0; ld = 4'h0; end
        return {ld, ud};
    endfunction

    // One scenario: configure, reset, run whole lines against the requirement model.
    task automatic run_case(input string tag, input int m, input int hp_drv,
                            input int hp, input int hn, input int duty,
                            input bit on, input int nlines);
        int  w, d, k, ln, lm, s, pulses, exp_pulses;
        bit  pend, pend_n, frm_exp;
        logic [7:0] pend_v, pend_vn;
        string dtag;
        w = (m == 0) ? 1 : (m == 1) ? 2 : 4;
        dtag = !on ? "R10" : (m == 0) ? "R4 R2" : (m == 1) ? "R5 R2" : "R6 R2";
        @(negedge clk);
        rst_n = 1'b0;
        mode_i = 2'(m); hp_m1_i = 3'(hp_drv); hn_m1_i = 7'(hn - 1);
        duty_m1_i = 8'(duty - 1); disp_on_i = on;
        upper_i = 8'hFF; lower_i = 8'hFF;
        repeat (2) @(negedge clk);
        // R11: reset state
        chk(ud_o == 0 && ld_o == 0, "R11", tag, {ld_o, ud_o}, 0);
        chk(!clp_o && !frm_o && !chr_o, "R11", tag, {clp_o, frm_o, chr_o}, 0);
        rst_n = 1'b1;
        d = 0; k = 0; ln = 0; lm = 0; pend = 0; pend_v = '0; frm_exp = 0; pulses = 0;
        for (int c = 0; c < nlines * (hn + 8) * hp; c++) begin
            chk(chr_o == (d == hp - 1), "R1", tag, chr_o, d == hp - 1);
            chk(busy_o == (k < 7), "R8", tag, busy_o, k < 7);
            chk(lip_o == (k == 1 || k == 2), "R8", tag, lip_o, k == 1 || k == 2);
            chk(ce_o == (k == 3), "R8", tag, ce_o, k == 3);
            chk(frm_o == frm_exp, "R9", tag, frm_o, frm_exp);
            chk(clp_o == pend, "R7", tag, clp_o, pend);
            if (clp_o) pulses++;
            if (pend && clp_o) chk({ld_o, ud_o} == pend_v, dtag, tag, {ld_o, ud_o}, pend_v);
            pend_n = 0; pend_vn = '0;
            if (k >= 8) begin
                s = (k - 8) * hp + d;
                if (s % w == w - 1) begin
                    pend_n = 1;
                    pend_vn = exp_lanes(m, ln, s - (w - 1), hp, on);
                end
            end
            if (d == hp - 1) begin
                upper_i = (k + 1 >= 8 && k + 1 < hn + 8) ? pat(ln, k - 7, 0) : 8'hA5;
                lower_i = (k + 1 >= 8 && k + 1 < hn + 8) ? pat(ln, k - 7, 1) : 8'h5A;
                d = 0;
                if (k == hn + 7) begin
                    k = 0; ln++;
                    if (lm == duty - 1) begin lm = 0; frm_exp = !frm_exp; end
                    else lm++;
                end else k++;
            end else d++;
            pend = pend_n; pend_v = pend_vn;
            @(negedge clk);
        end
        exp_pulses = nlines * ((hn * hp) / w);
        // Late pulse of the last line falls in the cycle just reached.
        if (pend && clp_o) pulses++;
        chk(pulses == exp_pulses, "R3", tag, pulses, exp_pulses);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        run_case("serial hp8",   0, 7, 8, 3, 2, 1'b1, 3);
        run_case("par2 hp5",     1, 4, 5, 3, 2, 1'b1, 3);
        run_case("par4 hp8",     2, 7, 8, 4, 2, 1'b1, 3);
        run_case("par4 hp5",     2, 4, 5, 3, 3, 1'b1, 4);
        run_case("mode3 hp6",    3, 5, 6, 2, 1, 1'b1, 3);
        run_case("display off",  0, 6, 7, 3, 2, 1'b0, 2);
        run_case("pitch clamp",  1, 1, 4, 3, 2, 1'b1, 2);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule